// File: doc/BRIEF.md
# PCI Power Management Capability Registers

This block holds the two dwords of a PCI power-management capability as seen from configuration space. The first dword carries a read-only capabilities word that reports version 2 and, per parameter, the power states from which the function can signal a wake event. The second dword carries the control/status word. That word has a two-bit power-state field, a wake enable bit, a sticky wake status bit that is cleared by writing a one, and a no-soft-reset bit fixed by a parameter.

The configuration layer writes through a dword index, a byte offset inside the dword and a byte count. The data bytes are packed from the least significant byte upward, so the byte written at the addressed offset always sits in the low byte of the data. The function raises `wake_req` when it wants to signal a wake. The block records this as wake status only when it is in D3 with wake enabled, and then drives `pme_out` as a level. Each write to the control dword that moves the decoded power state produces a one-cycle change event that carries both the old and the new states.

Top module: `pmcap_regs`

## Requirements
- R1: After reset the power state is 0 (D0), wake enable is 0, wake status is 0, and bit 3 equals the NO_SOFT_RST parameter.
- R2: A read of dword index 0 returns the capabilities word in bits [31:16] and zero in bits [15:0]. The capabilities word is 0x0002, ORed with bit 11 (wake from D0), bit 14 (wake from D3hot) and bit 15 (wake from D3cold) when the matching parameter is set. Reads of any index other than 0 and 1 return 0.
- R3: A read of dword index 1 returns the control/status word in bits [15:0] and zero in bits [31:16]. Its layout is: [1:0] power state, [3] no-soft-reset, [8] wake enable, [15] wake status, and all other bits 0.
- R4: A write to index 1 at byte offset 0 loads the power state from data bits [1:0]. When the byte count is 2 or 4, data bits [15:8] are also applied as the upper control byte.
- R5: A write to index 1 at byte offset 1 with a byte count of 1 applies data bits [7:0] as the upper control byte. Any other count at offset 1 changes nothing.
- R6: Writes to index 1 at byte offsets 2 and 3 change nothing, and so do writes to any index other than 1.
- R7: When the upper control byte is applied, its bit 0 becomes wake enable. If its bit 7 is 1, wake status is cleared. If its bit 7 is 0, wake status is left unchanged.
- R8: A `wake_req` sets wake status only when the power state (as it was before that clock edge) is 3 and wake enable is 1. Otherwise it has no effect.
- R9: One cycle after a write to index 1 whose decoded power state before and after differ, `chg_valid` pulses for one cycle, with `chg_from` and `chg_to` coded 0 = D0, 1 = D3, 2 = unsupported (encodings 1 and 2 both decode to unsupported). No event is produced otherwise.
- R10: `pme_out` is high exactly while wake status and wake enable are both 1. It falls in the cycle after either of them is cleared.
- R11: When a wake that meets R8 and a status-clearing write fall in the same cycle, wake status ends set.
- R12: No write can change bit 3 or any bit outside the writable mask 0x8103.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe, one cycle per access |
| cfg_wr_idx | input | IDX_W | Dword index of the write |
| cfg_wr_off | input | 2 | Byte offset of the write within the dword |
| cfg_wr_len | input | 3 | Byte count of the write (1 to 4) |
| cfg_wr_data | input | 16 | Write bytes packed from the addressed offset upward |
| cfg_rd_idx | input | IDX_W | Dword index to read |
| cfg_rd_data | output | 32 | Combinational read data |
| wake_req | input | 1 | Wake event request from the function |
| pme_out | output | 1 | Wake signal level |
| chg_valid | output | 1 | One-cycle power-state change pulse |
| chg_from | output | 2 | Decoded state before the change |
| chg_to | output | 2 | Decoded state after the change |

## Verification
Two functions can fall in the same cycle: a wake request, and a write whose upper byte clears wake status or changes the power state or enable. The bench provokes this by driving `wake_req` and the write strobe together on the same falling edge. It first places the block in D3 with wake enable set and status already set, and it also covers the case where the same write disables wake. It then judges the result with its own model, which evaluates the wake condition on the state from before the edge and applies the wake after the clear. This gives status set and `pme_out` following the enable bit left by the write.

// File: rtl/pmcap_pkg.sv
package pmcap_pkg;

  localparam int CTRL_W   = 16;
  localparam int BIT_NSR  = 3;
  localparam int BIT_EN   = 8;
  localparam int BIT_ST   = 15;
  localparam int CAP_VER  = 2;
  localparam int BIT_WD0  = 11;
  localparam int BIT_WD3H = 14;
  localparam int BIT_WD3C = 15;

  typedef enum logic [1:0] {
    PWR_D0    = 2'd0,
    PWR_D3    = 2'd1,
    PWR_UNSUP = 2'd2
  } pwr_e;

  typedef struct packed {
    logic       ps_we;
    logic [1:0] ps_val;
    logic       hi_we;
    logic       hi_en;
    logic       hi_clr;
  } wr_cmd_t;

  function automatic pwr_e decode_pwr(input logic [1:0] field);
    case (field)
      2'd0:    return PWR_D0;
      2'd3:    return PWR_D3;
      default: return PWR_UNSUP;
    endcase
  endfunction

  function automatic logic [CTRL_W-1:0] build_cap(input bit wd0, input bit wd3h,
                                                  input bit wd3c);
    logic [CTRL_W-1:0] w;
    w = CTRL_W'(CAP_VER);
    w[BIT_WD0]  = wd0;
    w[BIT_WD3H] = wd3h;
    w[BIT_WD3C] = wd3c;
    return w;
  endfunction

  function automatic logic [CTRL_W-1:0] pack_ctrl(input logic st, input logic en,
                                                  input logic nsr, input logic [1:0] ps);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[BIT_ST]  = st;
    w[BIT_EN]  = en;
    w[BIT_NSR] = nsr;
    w[1:0]     = ps;
    return w;
  endfunction

endpackage

// File: rtl/pmcap_wr_decode.sv
module pmcap_wr_decode
  import pmcap_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int CTRL_IDX = 1
) (
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       off,
  input  logic [2:0]       len,
  input  logic [15:0]      data,
  output wr_cmd_t          cmd,
  output logic             wr_hit,
  output logic             off_ignored
);

  logic       lo_path;
  logic       hi_from_lo;
  logic       hi_from_b1;
  logic [7:0] hi_byte;
  logic       unused_bits;

  assign wr_hit      = wr && (idx == IDX_W'(CTRL_IDX));
  assign lo_path     = wr_hit && (off == 2'd0);
  assign hi_from_lo  = lo_path && ((len == 3'd2) || (len == 3'd4));
  assign hi_from_b1  = wr_hit && (off == 2'd1) && (len == 3'd1);
  assign off_ignored = wr_hit && (off > 2'd1);

  assign hi_byte = hi_from_lo ? data[15:8] : data[7:0];

  always_comb begin
    cmd        = '0;
    cmd.ps_we  = lo_path;
    cmd.ps_val = data[1:0];
    cmd.hi_we  = hi_from_lo || hi_from_b1;
    cmd.hi_en  = hi_byte[0];
    cmd.hi_clr = hi_byte[7];
  end

  assign unused_bits = ^{hi_byte[6:1], data[7:2]};

endmodule

// File: rtl/pmcap_csr.sv
module pmcap_csr
  import pmcap_pkg::*;
#(
  parameter bit NO_SOFT_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_cmd_t           cmd,
  input  logic              wake_req,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [1:0]        ps_next,
  output logic              wake_hit,
  output logic              clr_hit
);

  logic [1:0] ps_q;
  logic       en_q;
  logic       st_q;
  logic       en_d;
  logic       st_d;

  assign wake_hit = wake_req && (ps_q == 2'd3) && en_q;
  assign clr_hit  = cmd.hi_we && cmd.hi_clr;

  assign ps_next = cmd.ps_we ? cmd.ps_val : ps_q;
  assign en_d    = cmd.hi_we ? cmd.hi_en : en_q;

  always_comb begin
    st_d = st_q;
    if (clr_hit)  st_d = 1'b0;
    if (wake_hit) st_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q <= 2'd0;
      en_q <= 1'b0;
      st_q <= 1'b0;
    end else begin
      ps_q <= ps_next;
      en_q <= en_d;
      st_q <= st_d;
    end
  end

  assign ctrl_q = pack_ctrl(st_q, en_q, NO_SOFT_RST, ps_q);

endmodule

// File: rtl/pmcap_chg_event.sv
module pmcap_chg_event
  import pmcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [1:0] ps_cur,
  input  logic [1:0] ps_nxt,
  output logic       chg_valid,
  output logic [1:0] chg_from,
  output logic [1:0] chg_to
);

  pwr_e dec_cur;
  pwr_e dec_nxt;
  logic moved;

  assign dec_cur = decode_pwr(ps_cur);
  assign dec_nxt = decode_pwr(ps_nxt);
  assign moved   = wr_hit && (dec_cur != dec_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_valid <= 1'b0;
      chg_from  <= 2'd0;
      chg_to    <= 2'd0;
    end else begin
      chg_valid <= moved;
      if (moved) begin
        chg_from <= dec_cur;
        chg_to   <= dec_nxt;
      end
    end
  end

endmodule

// File: rtl/pmcap_regs.sv
module pmcap_regs
  import pmcap_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter bit WAKE_D0     = 1'b1,
  parameter bit WAKE_D3HOT  = 1'b1,
  parameter bit WAKE_D3COLD = 1'b1,
  parameter bit NO_SOFT_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_wr_idx,
  input  logic [1:0]       cfg_wr_off,
  input  logic [2:0]       cfg_wr_len,
  input  logic [15:0]      cfg_wr_data,
  input  logic [IDX_W-1:0] cfg_rd_idx,
  output logic [31:0]      cfg_rd_data,
  input  logic             wake_req,
  output logic             pme_out,
  output logic             chg_valid,
  output logic [1:0]       chg_from,
  output logic [1:0]       chg_to
);

  localparam int CAP_IDX  = 0;
  localparam int CTRL_IDX = 1;
  localparam logic [CTRL_W-1:0] CAP_WORD = build_cap(WAKE_D0, WAKE_D3HOT, WAKE_D3COLD);

  wr_cmd_t           cmd;
  logic              wr_hit;
  logic              off_ignored;
  logic [CTRL_W-1:0] ctrl_q;
  logic [1:0]        ps_next;
  logic              wake_hit;
  logic              clr_hit;

  pmcap_wr_decode #(.IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX)) u_dec (
    .wr          (cfg_wr),
    .idx         (cfg_wr_idx),
    .off         (cfg_wr_off),
    .len         (cfg_wr_len),
    .data        (cfg_wr_data),
    .cmd         (cmd),
    .wr_hit      (wr_hit),
    .off_ignored (off_ignored)
  );

  pmcap_csr #(.NO_SOFT_RST(NO_SOFT_RST)) u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .wake_req (wake_req),
    .ctrl_q   (ctrl_q),
    .ps_next  (ps_next),
    .wake_hit (wake_hit),
    .clr_hit  (clr_hit)
  );

  pmcap_chg_event u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .ps_cur    (ctrl_q[1:0]),
    .ps_nxt    (ps_next),
    .chg_valid (chg_valid),
    .chg_from  (chg_from),
    .chg_to    (chg_to)
  );

  assign pme_out = ctrl_q[BIT_ST] && ctrl_q[BIT_EN];

  always_comb begin
    if (cfg_rd_idx == IDX_W'(CAP_IDX))
      cfg_rd_data = {CAP_WORD, 16'h0000};
    else if (cfg_rd_idx == IDX_W'(CTRL_IDX))
      cfg_rd_data = {16'h0000, ctrl_q};
    else
      cfg_rd_data = 32'h0;
  end

endmodule

// File: rtl/pmcap_regs_chk.sv
module pmcap_regs_chk
  import pmcap_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_hit,
  input logic        off_ignored,
  input logic        wake_hit,
  input logic        clr_hit,
  input logic [15:0] ctrl_q,
  input logic        pme_out,
  input logic        chg_valid,
  input logic [1:0]  chg_from,
  input logic [1:0]  chg_to
);

  AST_WAKE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |=> ctrl_q[BIT_ST]); // R8

  AST_STATUS_RISE_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[BIT_ST]) |-> $past(wake_hit)); // R8

  AST_WAKE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_hit && clr_hit) |=> ctrl_q[BIT_ST]); // R11

  AST_HIGH_OFFSET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (off_ignored && !wake_hit) |=> $stable(ctrl_q)); // R6

  AST_PME_DROPS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !wake_hit) |=> !pme_out); // R10

  AST_CHG_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> $past(wr_hit)); // R9

  AST_CHG_STATES_DIFFER: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> (chg_from != chg_to)); // R9

  AST_CHG_TO_MATCHES_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> (chg_to == 2'(decode_pwr(ctrl_q[1:0])))); // R9

endmodule

bind pmcap_regs pmcap_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_hit      (wr_hit),
  .off_ignored (off_ignored),
  .wake_hit    (wake_hit),
  .clr_hit     (clr_hit),
  .ctrl_q      (ctrl_q),
  .pme_out     (pme_out),
  .chg_valid   (chg_valid),
  .chg_from    (chg_from),
  .chg_to      (chg_to)
);

// File: tb/pmcap_regs_tb.sv
module pmcap_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_wr = 1'b0;
  logic [IDX_W-1:0] cfg_wr_idx = '0;
  logic [1:0]       cfg_wr_off = '0;
  logic [2:0]       cfg_wr_len = '0;
  logic [15:0]      cfg_wr_data = '0;
  logic [IDX_W-1:0] cfg_rd_idx = 4'd1;
  logic [31:0]      cfg_rd_data;
  logic             wake_req = 1'b0;
  logic             pme_out;
  logic             chg_valid;
  logic [1:0]       chg_from;
  logic [1:0]       chg_to;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // bench model
  logic [1:0] m_ps;
  logic       m_en;
  logic       m_st;
  logic       m_cv;
  logic [1:0] m_cf;
  logic [1:0] m_ct;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmcap_regs #(
    .IDX_W(IDX_W), .WAKE_D0(1'b1), .WAKE_D3HOT(1'b1), .WAKE_D3COLD(1'b1),
    .NO_SOFT_RST(1'b1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wr_idx(cfg_wr_idx),
    .cfg_wr_off(cfg_wr_off), .cfg_wr_len(cfg_wr_len), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data), .wake_req(wake_req),
    .pme_out(pme_out), .chg_valid(chg_valid), .chg_from(chg_from), .chg_to(chg_to)
  );

  function automatic logic [1:0] code_of(input logic [1:0] f);
    if (f == 2'd0) return 2'd0;
    if (f == 2'd3) return 2'd1;
    return 2'd2;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [IDX_W-1:0] idx, input logic [1:0] off,
                        input logic [2:0] len, input logic [15:0] d, input bit wk);
    logic [1:0] old_ps;
    bit wake_ok;
    bit hi;
    logic [7:0] hb;
    old_ps  = m_ps;
    wake_ok = wk && (m_ps == 2'd3) && m_en;
    hi = 1'b0;
    hb = 8'h00;
    if (wr && idx == 4'd1) begin
      if (off == 2'd0) begin
        m_ps = d[1:0];
        if (len == 3'd2 || len == 3'd4) begin hi = 1'b1; hb = d[15:8]; end
      end else if (off == 2'd1 && len == 3'd1) begin
        hi = 1'b1; hb = d[7:0];
      end
    end
    if (hi) begin
      m_en = hb[0];
      if (hb[7]) m_st = 1'b0;
    end
    if (wake_ok) m_st = 1'b1;
    m_cv = wr && (idx == 4'd1) && (code_of(old_ps) != code_of(m_ps));
    if (m_cv) begin m_cf = code_of(old_ps); m_ct = code_of(m_ps); end
    @(negedge clk);
    cfg_wr = wr; cfg_wr_idx = idx; cfg_wr_off = off; cfg_wr_len = len;
    cfg_wr_data = d; wake_req = wk;
    @(negedge clk);
    cfg_wr = 1'b0; wake_req = 1'b0;
  endtask

  function automatic logic [31:0] exp_ctrl();
    return {16'h0, m_st, 6'b0, m_en, 4'b0, 1'b1, 1'b0, m_ps};
  endfunction

  task automatic check_all(input string req);
    check(req, cfg_rd_data, exp_ctrl());
    check("R10", {31'b0, pme_out}, {31'b0, m_st & m_en});
    check("R9", {31'b0, chg_valid}, {31'b0, m_cv});
    if (m_cv) check("R9", {28'b0, chg_from, chg_to}, {28'b0, m_cf, m_ct});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_ps = 2'd0; m_en = 1'b0; m_st = 1'b0; m_cv = 1'b0; m_cf = 2'd0; m_ct = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 reset state, R2 capability dword and unused index
    check("R1", cfg_rd_data, 32'h0000_0008);
    check("R1", {31'b0, pme_out}, 32'h0);
    cfg_rd_idx = 4'd0; #1;
    check("R2", cfg_rd_data, {16'h0002 | 16'h0800 | 16'h4000 | 16'h8000, 16'h0});
    cfg_rd_idx = 4'd2; #1;
    check("R2", cfg_rd_data, 32'h0);
    cfg_rd_idx = 4'd1; #1;

    // R8: wake in D0 with enable has no effect
    access(1, 4'd1, 2'd0, 3'd2, 16'h0100, 0); check_all("R4");
    access(0, 4'd1, 2'd0, 3'd1, 16'h0000, 1); check_all("R8");
    // R8: wake in D3 with enable clear has no effect
    access(1, 4'd1, 2'd0, 3'd2, 16'h0003, 0); check_all("R4");
    access(0, 4'd1, 2'd0, 3'd1, 16'h0000, 1); check_all("R8");
    // R8 R10: wake in D3 with enable sets status and PME
    access(1, 4'd1, 2'd1, 3'd1, 16'h0001, 0); check_all("R5");
    access(0, 4'd1, 2'd0, 3'd1, 16'h0000, 1); check_all("R8");
    // R11: wake together with a clearing write
    access(1, 4'd1, 2'd1, 3'd1, 16'h0081, 1); check_all("R11");
    // R11 with the same write dropping enable: status set, PME low
    access(1, 4'd1, 2'd1, 3'd1, 16'h0080, 1); check_all("R11");
    // R10: enable back on with status still set
    access(1, 4'd1, 2'd1, 3'd1, 16'h0001, 0); check_all("R10");
    // R7: writing 0 to status bit leaves it
    access(1, 4'd1, 2'd1, 3'd1, 16'h0001, 0); check_all("R7");
    // R6: writes to index 0 and index 3 ignored
    access(1, 4'd0, 2'd0, 3'd4, 16'h0080, 0); check_all("R6");
    access(1, 4'd3, 2'd1, 3'd1, 16'h0080, 0); check_all("R6");
    // R12: bit 3 and non-writable bits fixed
    access(1, 4'd1, 2'd0, 3'd2, 16'hFFF4, 0); check_all("R12");
    // R9: 1 -> 2 both unsupported, no event
    access(1, 4'd1, 2'd0, 3'd1, 16'h0001, 0); check_all("R9");
    access(1, 4'd1, 2'd0, 3'd1, 16'h0002, 0); check_all("R9");

    // R4 R5 R6 R7 R9 R10: sweep of offset, length and data pattern
    for (int o = 0; o < 4; o++) begin
      for (int c = 1; c <= 4; c++) begin
        for (int p = 0; p < 4; p++) begin
          logic [15:0] pat;
          string rq;
          pat = (p == 0) ? 16'h0102 : (p == 1) ? 16'h8001 :
                (p == 2) ? 16'h0081 : 16'hFFFF;
          rq  = (o == 0) ? "R4" : (o == 1) ? "R5" : "R6";
          access(1, 4'd1, 2'd0, 3'd2, 16'h0103, 0);
          access(0, 4'd1, 2'd0, 3'd1, 16'h0000, 1);
          access(1, 4'd1, 2'(o), 3'(c), pat, 0);
          check_all(rq);
        end
      end
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule